// File: doc/BRIEF.md
# Single-to-Double Precision Conversion Unit

This block widens one 32-bit IEEE-754 single-precision number into the double-precision number of the same value, and places the 64-bit result in the lowest lane of a 512-bit vector destination. The conversion is always exact, so no rounding takes place. Subnormal inputs are normalised, and signalling NaNs are quietened. Only two exception flags are reported: Invalid and Denormal.

The rest of the destination register is formed by one of three write-back policies, picked per operation. The first policy keeps every upper bit of the old destination. The second copies bits 127:64 from a first-source vector and clears everything above bit 127. The third applies the same upper-lane rule as the second and adds a one-bit writemask over the low lane. With that mask, an element that is masked off either keeps its old contents or is cleared.

The unit is a single register stage. A result and its flags appear one clock after an input strobe, together with an output strobe.

Top module: `f2d_convert_unit`

## Requirements
- R1: For a normal input with sign s, biased exponent e and fraction f, the result is sign s, exponent e+896 and fraction {f, 29 zero bits}. No flag is raised.
- R2: When `wb_mode` is 0 (keep policy), `dst_out[511:64]` equals `prev_dst[511:64]`.
- R3: When `wb_mode` is 1, 2 or 3, `dst_out[127:64]` equals `src_vec[127:64]` and `dst_out[511:128]` is zero. Mode 3 behaves exactly as mode 1.
- R4: When `wb_mode` is 2 and either `mask_bit` is 1 or `mask_en` is 0, `dst_out[63:0]` holds the converted value.
- R5: When `wb_mode` is 2, `mask_en` is 1 and `mask_bit` is 0, `dst_out[63:0]` holds `prev_dst[63:0]` if `zero_sel` is 0 and holds zero if `zero_sel` is 1. In both cases no flag is raised, and the upper lanes follow R3.
- R6: A subnormal input (exponent 0, fraction not zero) raises `flag_denormal`. The result is normalised: its exponent is 896 minus the count of leading zeros in the 23-bit fraction, and its fraction is the input fraction with the leading one removed, aligned to the top.
- R7: A NaN input with fraction bit 22 clear raises `flag_invalid`. A NaN input with bit 22 set raises no flag. In both cases the result is a quiet NaN: exponent all ones, fraction bit 51 set, and fraction bits 50:29 taken from input bits 21:0.
- R8: A zero or infinite input keeps its sign, maps to the double zero or infinity encoding, and raises no flag.
- R9: `out_valid` is high exactly one clock after each cycle with `in_valid` high, and is low otherwise. A synchronous `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| wb_mode | input | 2 | Write-back policy: 0 keep, 1 copy-and-clear, 2 masked, 3 same as 1 |
| prev_dst | input | 512 | Previous destination contents |
| src_vec | input | 512 | First source vector; bits 127:64 are used |
| cvt_src | input | 32 | Single-precision operand |
| mask_bit | input | 1 | Writemask bit for the low element |
| mask_en | input | 1 | Masking enabled (mode 2 only) |
| zero_sel | input | 1 | 1 = zero masked element, 0 = merge |
| out_valid | output | 1 | Result strobe |
| dst_out | output | 512 | New destination contents |
| flag_invalid | output | 1 | Signalling NaN seen |
| flag_denormal | output | 1 | Subnormal input seen |

## Verification
The hardest case to reach is a masked-off element whose operand would itself raise a flag. A flag on such an element must be suppressed, and a merge must return the old low lane bit for bit. To reach it, the stimulus sends a signalling NaN and a subnormal under mask in both the merging and the zeroing forms. The low half of the old destination carries a distinctive pattern, so a wrong source would show. Back-to-back operations, with modes changing every cycle, make sure that no policy leaks from one operation into the next.

// File: rtl/f2d_pkg.sv
package f2d_pkg;
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_W      = 64;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_BIAS   = 127;
    localparam int DP_BIAS   = 1023;
    localparam int BIAS_GAP  = DP_BIAS - SP_BIAS;
    localparam int FRAC_PAD  = DP_FRAC_W - SP_FRAC_W;

    typedef enum logic [1:0] {
        WB_KEEP   = 2'd0,
        WB_COPY   = 2'd1,
        WB_MASKED = 2'd2,
        WB_ALT    = 2'd3
    } wb_mode_e;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_SUBN,
        CL_NORM,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } sp_class_e;
endpackage

// File: rtl/f2d_lzc.sv
module f2d_lzc #(
    parameter int W  = 23,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] zeros_o
);
    always_comb begin
        zeros_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                zeros_o = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/f2d_sp_to_dp.sv
module f2d_sp_to_dp
    import f2d_pkg::*;
(
    input  logic [SP_W-1:0] sp_i,
    output logic [DP_W-1:0] dp_o,
    output logic            invalid_o,
    output logic            denormal_o
);
    localparam int LZW = $clog2(SP_FRAC_W + 1);

    logic                 sign;
    logic [SP_EXP_W-1:0]  exp_in;
    logic [SP_FRAC_W-1:0] frac_in;
    logic [LZW-1:0]       lead_zeros;
    logic [SP_FRAC_W:0]   frac_shifted;
    sp_class_e            cls;

    assign sign    = sp_i[SP_W-1];
    assign exp_in  = sp_i[SP_W-2 -: SP_EXP_W];
    assign frac_in = sp_i[SP_FRAC_W-1:0];

    f2d_lzc #(.W(SP_FRAC_W), .CW(LZW)) i_lzc (
        .vec_i   (frac_in),
        .zeros_o (lead_zeros)
    );

    assign frac_shifted = {frac_in, 1'b0} << lead_zeros;

    always_comb begin
        if (exp_in == '0) begin
            cls = (frac_in == '0) ? CL_ZERO : CL_SUBN;
        end else if (exp_in == '1) begin
            if (frac_in == '0)                cls = CL_INF;
            else if (frac_in[SP_FRAC_W-1])    cls = CL_QNAN;
            else                              cls = CL_SNAN;
        end else begin
            cls = CL_NORM;
        end
    end

    always_comb begin
        invalid_o  = 1'b0;
        denormal_o = 1'b0;
        unique case (cls)
            CL_ZERO: dp_o = {sign, {(DP_W-1){1'b0}}};
            CL_SUBN: begin
                denormal_o = 1'b1;
                dp_o = {sign,
                        DP_EXP_W'(BIAS_GAP) - DP_EXP_W'(lead_zeros),
                        frac_shifted[SP_FRAC_W-1:0], {FRAC_PAD{1'b0}}};
            end
            CL_NORM: dp_o = {sign,
                             DP_EXP_W'(exp_in) + DP_EXP_W'(BIAS_GAP),
                             frac_in, {FRAC_PAD{1'b0}}};
            CL_INF:  dp_o = {sign, {DP_EXP_W{1'b1}}, {DP_FRAC_W{1'b0}}};
            CL_QNAN, CL_SNAN: begin
                invalid_o = (cls == CL_SNAN);
                dp_o = {sign, {DP_EXP_W{1'b1}}, 1'b1,
                        frac_in[SP_FRAC_W-2:0], {FRAC_PAD{1'b0}}};
            end
            default: dp_o = '0;
        endcase
    end
endmodule

// File: rtl/f2d_lane_writeback.sv
module f2d_lane_writeback
    import f2d_pkg::*;
#(
    parameter int DST_W  = 512,
    parameter int LANE_W = 64,
    parameter int KEEP_W = 128
) (
    input  logic [1:0]       mode_i,
    input  logic [DST_W-1:0] prev_i,
    input  logic [DST_W-1:0] src_i,
    input  logic [LANE_W-1:0] conv_i,
    input  logic             mask_bit_i,
    input  logic             mask_en_i,
    input  logic             zero_sel_i,
    output logic [DST_W-1:0] dst_o,
    output logic             masked_off_o
);
    localparam int NLANE = DST_W / LANE_W;
    localparam int NKEEP = KEEP_W / LANE_W;

    wb_mode_e mode;
    logic     keep_upper;

    assign mode         = wb_mode_e'(mode_i);
    assign keep_upper   = (mode == WB_KEEP);
    assign masked_off_o = (mode == WB_MASKED) && mask_en_i && !mask_bit_i;

    always_comb begin
        if (!masked_off_o)   dst_o[LANE_W-1:0] = conv_i;
        else if (zero_sel_i) dst_o[LANE_W-1:0] = '0;
        else                 dst_o[LANE_W-1:0] = prev_i[LANE_W-1:0];
    end

    for (genvar g = 1; g < NLANE; g++) begin : g_lane
        if (g < NKEEP) begin : g_copy
            assign dst_o[g*LANE_W +: LANE_W] = keep_upper ? prev_i[g*LANE_W +: LANE_W]
                                                          : src_i[g*LANE_W +: LANE_W];
        end else begin : g_clear
            assign dst_o[g*LANE_W +: LANE_W] = keep_upper ? prev_i[g*LANE_W +: LANE_W]
                                                          : '0;
        end
    end
endmodule

// File: rtl/f2d_convert_unit.sv
module f2d_convert_unit
    import f2d_pkg::*;
#(
    parameter int DST_W  = 512,
    parameter int LANE_W = 64,
    parameter int KEEP_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       wb_mode,
    input  logic [DST_W-1:0] prev_dst,
    input  logic [DST_W-1:0] src_vec,
    input  logic [31:0]      cvt_src,
    input  logic             mask_bit,
    input  logic             mask_en,
    input  logic             zero_sel,
    output logic             out_valid,
    output logic [DST_W-1:0] dst_out,
    output logic             flag_invalid,
    output logic             flag_denormal
);
    typedef struct packed {
        logic             valid;
        logic [DST_W-1:0] dst;
        logic             inv;
        logic             den;
    } stage_t;

    stage_t st_d, st_q;

    logic [DP_W-1:0]  conv;
    logic             conv_inv, conv_den;
    logic [DST_W-1:0] wb_dst;
    logic             masked_off;

    f2d_sp_to_dp i_cvt (
        .sp_i       (cvt_src),
        .dp_o       (conv),
        .invalid_o  (conv_inv),
        .denormal_o (conv_den)
    );

    f2d_lane_writeback #(.DST_W(DST_W), .LANE_W(LANE_W), .KEEP_W(KEEP_W)) i_wb (
        .mode_i       (wb_mode),
        .prev_i       (prev_dst),
        .src_i        (src_vec),
        .conv_i       (conv[LANE_W-1:0]),
        .mask_bit_i   (mask_bit),
        .mask_en_i    (mask_en),
        .zero_sel_i   (zero_sel),
        .dst_o        (wb_dst),
        .masked_off_o (masked_off)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.dst = wb_dst;
            st_d.inv = conv_inv && !masked_off;
            st_d.den = conv_den && !masked_off;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid     = st_q.valid;
    assign dst_out       = st_q.dst;
    assign flag_invalid  = st_q.inv;
    assign flag_denormal = st_q.den;
endmodule

// File: rtl/f2d_convert_chk.sv
module f2d_convert_chk #(
    parameter int DST_W  = 512,
    parameter int KEEP_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       wb_mode,
    input logic [DST_W-1:0] prev_dst,
    input logic [DST_W-1:0] src_vec,
    input logic             mask_bit,
    input logic             mask_en,
    input logic             zero_sel,
    input logic             out_valid,
    input logic [DST_W-1:0] dst_out,
    input logic             flag_invalid,
    input logic             flag_denormal
);
    a_r9_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r2_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wb_mode == 2'd0) |=> dst_out[DST_W-1:64] == $past(prev_dst[DST_W-1:64]));

    a_r3_upper_cleared: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wb_mode != 2'd0) |=> dst_out[DST_W-1:KEEP_W] == '0);

    a_r3_mid_copied: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wb_mode != 2'd0) |=> dst_out[KEEP_W-1:64] == $past(src_vec[KEEP_W-1:64]));

    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wb_mode == 2'd2 && mask_en && !mask_bit)
        |=> (!flag_invalid && !flag_denormal));

    a_r5_merge_keeps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wb_mode == 2'd2 && mask_en && !mask_bit && !zero_sel)
        |=> dst_out[63:0] == $past(prev_dst[63:0]));

    a_r5_zeroing: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wb_mode == 2'd2 && mask_en && !mask_bit && zero_sel)
        |=> dst_out[63:0] == '0);

    a_r7_flags_apart: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(flag_invalid && flag_denormal));
endmodule

bind f2d_convert_unit f2d_convert_chk #(.DST_W(DST_W), .KEEP_W(KEEP_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .wb_mode       (wb_mode),
    .prev_dst      (prev_dst),
    .src_vec       (src_vec),
    .mask_bit      (mask_bit),
    .mask_en       (mask_en),
    .zero_sel      (zero_sel),
    .out_valid     (out_valid),
    .dst_out       (dst_out),
    .flag_invalid  (flag_invalid),
    .flag_denormal (flag_denormal)
);

// File: tb/test_f2d_convert_unit.sv
module test_f2d_convert_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   wb_mode = 2'd0;
    logic [511:0] prev_dst = '0;
    logic [511:0] src_vec = '0;
    logic [31:0]  cvt_src = '0;
    logic         mask_bit = 1'b0;
    logic         mask_en = 1'b0;
    logic         zero_sel = 1'b0;
    logic         out_valid;
    logic [511:0] dst_out;
    logic         flag_invalid;
    logic         flag_denormal;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [511:0] dst;
        logic         inv;
        logic         den;
        int           due;
        string        tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    f2d_convert_unit i_f2d_convert_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wb_mode(wb_mode),
        .prev_dst(prev_dst), .src_vec(src_vec), .cvt_src(cvt_src),
        .mask_bit(mask_bit), .mask_en(mask_en), .zero_sel(zero_sel),
        .out_valid(out_valid), .dst_out(dst_out),
        .flag_invalid(flag_invalid), .flag_denormal(flag_denormal)
    );

    task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_cvt(input logic [31:0] a, output logic inv, output logic den);
        int ex;
        logic [23:0] m;
        logic [51:0] fr;
        inv = 1'b0;
        den = 1'b0;
        if (a[30:23] == 8'hFF) begin
            if (a[22:0] == 23'h0) return {a[31], 11'h7FF, 52'h0};
            inv = ~a[22];
            fr = {a[22:0], 29'h0};
            fr[51] = 1'b1;
            return {a[31], 11'h7FF, fr};
        end
        if (a[30:23] == 8'h00) begin
            if (a[22:0] == 23'h0) return {a[31], 63'h0};
            den = 1'b1;
            m = {1'b0, a[22:0]};
            ex = -126;
            while (!m[23]) begin
                m = m << 1;
                ex--;
            end
            return {a[31], 11'(ex + 1023), m[22:0], 29'h0};
        end
        return {a[31], 11'(int'(a[30:23]) - 127 + 1023), a[22:0], 29'h0};
    endfunction

    task automatic send(input logic [1:0] md, input logic [511:0] pv, input logic [511:0] sv,
                        input logic [31:0] a, input bit mb, input bit me, input bit zs,
                        input string tag);
        item_t it;
        logic [63:0] conv, low;
        logic inv, den;
        bit masked;
        @(negedge clk);
        wb_mode = md; prev_dst = pv; src_vec = sv; cvt_src = a;
        mask_bit = mb; mask_en = me; zero_sel = zs; in_valid = 1'b1;
        conv = ref_cvt(a, inv, den);
        masked = (md == 2'd2) && me && !mb;
        if (masked) begin
            low = zs ? 64'h0 : pv[63:0];
            inv = 1'b0;
            den = 1'b0;
        end else begin
            low = conv;
        end
        if (md == 2'd0) it.dst = {pv[511:64], low};
        else            it.dst = {384'h0, sv[127:64], low};
        it.inv = inv;
        it.den = den;
        it.due = cyc + 1;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9 unexpected out_valid", 512'(out_valid), 512'(0));
                end else begin
                    it = sb.pop_front();
                    check(cyc == it.due, {it.tag, " R9 latency"}, 512'(cyc), 512'(it.due));
                    check(dst_out === it.dst, {it.tag, " dst"}, dst_out, it.dst);
                    check(flag_invalid === it.inv, {it.tag, " invalid"}, 512'(flag_invalid), 512'(it.inv));
                    check(flag_denormal === it.den, {it.tag, " denormal"}, 512'(flag_denormal), 512'(it.den));
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stimulus
        logic [511:0] pv, sv;
        pv = {16{32'hC0DE_5A5A}};
        sv = {16{32'h1357_9BDF}};
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R9 reset clears out_valid", 512'(out_valid), 512'(0));
        rst = 1'b0;
        idle(2);
        check(out_valid === 1'b0, "R9 idle after reset", 512'(out_valid), 512'(0));

        send(2'd0, pv, sv, 32'h3F80_0000, 1'b0, 1'b0, 1'b0, "R1 R2 one keep");
        send(2'd1, pv, sv, 32'hC020_0000, 1'b0, 1'b0, 1'b0, "R1 R3 -2.5 copy");
        send(2'd3, ~pv, ~sv, 32'h4B7F_FFFF, 1'b0, 1'b0, 1'b0, "R1 R3 alt mode");
        send(2'd2, pv, sv, 32'h0000_0001, 1'b1, 1'b1, 1'b0, "R4 R6 min subnormal");
        send(2'd2, pv, sv, 32'h8040_0000, 1'b0, 1'b0, 1'b1, "R4 R6 max bit subnormal no mask");
        send(2'd0, pv, sv, 32'h0012_3456, 1'b0, 1'b0, 1'b0, "R6 mid subnormal");
        send(2'd1, pv, sv, 32'h7F80_0001, 1'b0, 1'b0, 1'b0, "R7 signalling NaN");
        send(2'd0, pv, sv, 32'hFFC0_1234, 1'b0, 1'b0, 1'b0, "R7 quiet NaN");
        send(2'd1, pv, sv, 32'h7FBF_FFFF, 1'b0, 1'b0, 1'b0, "R7 signalling NaN full payload");
        send(2'd0, pv, sv, 32'h0000_0000, 1'b0, 1'b0, 1'b0, "R8 plus zero");
        send(2'd1, pv, sv, 32'h8000_0000, 1'b0, 1'b0, 1'b0, "R8 minus zero");
        send(2'd2, pv, sv, 32'h7F80_0000, 1'b1, 1'b1, 1'b1, "R8 plus inf");
        send(2'd0, pv, sv, 32'hFF80_0000, 1'b0, 1'b0, 1'b0, "R8 minus inf");
        send(2'd2, pv, sv, 32'h4049_0FDB, 1'b0, 1'b1, 1'b0, "R5 merge normal");
        send(2'd2, pv, sv, 32'h7F80_0001, 1'b0, 1'b1, 1'b0, "R5 merge snan quiet");
        send(2'd2, pv, sv, 32'h0000_0003, 1'b0, 1'b1, 1'b1, "R5 zero subnormal quiet");
        send(2'd2, pv, sv, 32'h4049_0FDB, 1'b0, 1'b1, 1'b1, "R5 zeroing normal");
        send(2'd2, pv, sv, 32'h0080_0000, 1'b1, 1'b1, 1'b1, "R4 R1 min normal mask set");
        idle(3);
        check(out_valid === 1'b0, "R9 idle low", 512'(out_valid), 512'(0));

        send(2'd1, pv, sv, 32'h3F80_0000, 1'b0, 1'b0, 1'b0, "R9 before reset");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        void'(sb.pop_front());
        @(negedge clk);
        check(out_valid === 1'b0, "R9 reset drops pending", 512'(out_valid), 512'(0));
        rst = 1'b0;
        idle(2);
        check(sb.size() == 0, "R9 all results seen", 512'(sb.size()), 512'(0));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule